// File: doc/BRIEF.md
# Rotating Four-Lane PWM Bit Discriminator

This block recovers a serial bit stream from one pulse-width-modulated line that carries no companion clock. Every bit occupies one input period, and the periods have a fixed length. The bit value depends on the pulse width. If the line stays high for more than half of the period, the bit is 1. If it stays high for half the period or less, the bit is 0. A fast local clock is used only as a ruler to measure time. The block finds each period boundary from the rising edges of the line itself.

The block holds four identical decoding lanes. Each lane works through four steps, and each step lasts one input period:

- It builds a half-weight reference over one whole period.
- It measures the high time of the next period at double weight.
- It holds both amounts while the comparison is made.
- It publishes the result and clears its counters.

The lanes are offset from one another by one step, so one bit leaves the block on every input period. The bits leave on output lanes 0, 1, 2 and 3 in turn, and each bit comes with a one-cycle valid strobe.

Top module: `pwm_rot_discrim`

## Requirements
- R1: While reset is asserted, every bit output and every valid strobe is 0.
- R2: The input passes through two synchronizer flops. A new input period starts on every clock in which the synchronized level is high and was low on the clock before.
- R3: A global period counter (modulo 4) advances on each period start. Lane i is in step (period − i) mod 4, with the steps encoded as 0 precharge, 1 sample, 2 compare, 3 reset. The clock on which a period starts already belongs to the new step.
- R4: During precharge, a lane adds 1 to its reference counter on every clock of the period. The reference therefore equals the period length in clocks.
- R5: During sample, a lane adds 2 to its sample counter on every clock in which the synchronized input is high. When the input is low, the counter holds its value.
- R6: The decoded bit is 1 only when the sample count is strictly greater than the reference count. A tie gives 0.
- R7: On the period start that moves a lane from compare into reset, the lane latches its decoded bit and raises its valid strobe for exactly one clock. At all other times its bit output holds its value. As a result, the bit measured in period k is published at the start of period k+2, and the lanes publish in the order 0, 1, 2, 3 and then wrap back to 0.
- R8: While a lane is in reset, both of its counters are cleared to 0.
- R9: Both counters are 16 bits wide. They saturate at 65535 and never wrap.
- R10: No more than one valid strobe is high on any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock, used as the time ruler |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM data line, asynchronous to clk |
| bit_out | output | 4 | Latched decoded bit, one per lane |
| bit_vld | output | 4 | One-clock strobe per lane, high when that lane's bit is updated |

## Verification
The hardest condition to reach is counter saturation during the sample step. Reaching it takes a high time longer than 32767 clocks, and the period before it must be long too, because that earlier period sets the reference. The stimulus therefore sends two periods of 40000 clocks back to back, the second one high for 35000 clocks. Without saturation this bit would decode as 0; with saturation it must decode as 1. The stimulus also changes the period length between bits. This shows that each bit is judged against the period before it. It also hits the exact tie case, where twice the high time equals the reference.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;

  localparam int NUM_LANES = 4;

  typedef enum logic [1:0] {
    STEP_PRECHARGE = 2'd0,
    STEP_SAMPLE    = 2'd1,
    STEP_COMPARE   = 2'd2,
    STEP_RESET     = 2'd3
  } step_e;

  // Step of a lane, given the global phase and the lane's rotation offset.
  function automatic step_e lane_step(input logic [1:0] phase, input int unsigned idx);
    logic [1:0] diff;
    diff = phase - 2'(idx);
    return step_e'(diff);
  endfunction

endpackage

// File: rtl/pwmd_edge_sync.sv
module pwmd_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  output logic level,
  output logic rise
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pwm_in};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign level = sync_q[SYNC_STAGES-1];
  assign rise  = level & ~prev_q;

  AST_RISE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R2

endmodule

// File: rtl/pwmd_phase_gen.sv
module pwmd_phase_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise,
  output logic [1:0] phase_eff
);

  logic [1:0] phase_q, phase_d;

  // The clock on which a period starts already belongs to the new step.
  always_comb begin
    phase_eff = phase_q + {1'b0, rise};
    phase_d   = phase_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 2'd0;
    else        phase_q <= phase_d;
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(phase_q)); // R3

endmodule

// File: rtl/pwmd_lane.sv
module pwmd_lane
  import pwmd_pkg::*;
#(
  parameter int          CNT_W    = 16,
  parameter int unsigned LANE_IDX = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] phase_eff,
  input  logic       rise,
  input  logic       level,
  output logic       bit_o,
  output logic       vld_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

  step_e            step;
  logic [CNT_W-1:0] ref_q, ref_d, smp_q, smp_d;
  logic             ref_en, smp_en;
  logic             bit_q, bit_d, vld_q, vld_d;
  logic             latch_en, decision;

  always_comb begin
    step     = lane_step(phase_eff, LANE_IDX);
    decision = (smp_q > ref_q);
    latch_en = rise && (step == STEP_RESET);

    ref_en = 1'b0;
    ref_d  = ref_q;
    smp_en = 1'b0;
    smp_d  = smp_q;

    unique case (step)
      STEP_PRECHARGE: begin
        ref_en = (ref_q != CNT_MAX);
        ref_d  = ref_q + CNT_ONE;
      end
      STEP_SAMPLE: begin
        smp_en = level;
        smp_d  = (smp_q > CNT_MAX - CNT_TWO) ? CNT_MAX : smp_q + CNT_TWO;
      end
      STEP_COMPARE: begin
        ref_en = 1'b0;
        smp_en = 1'b0;
      end
      STEP_RESET: begin
        ref_en = 1'b1;
        ref_d  = '0;
        smp_en = 1'b1;
        smp_d  = '0;
      end
      default: begin
        ref_en = 1'b0;
        smp_en = 1'b0;
      end
    endcase

    bit_d = latch_en ? decision : bit_q;
    vld_d = latch_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      smp_q <= '0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      if (ref_en)   ref_q <= ref_d;
      if (smp_en)   smp_q <= smp_d;
      if (latch_en) bit_q <= bit_d;
      vld_q <= vld_d;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;

  AST_REF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_PRECHARGE && ref_q == CNT_MAX) |=> (ref_q == CNT_MAX)); // R9
  AST_SMP_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_SAMPLE && !level) |=> $stable(smp_q)); // R5
  AST_SMP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_SAMPLE) |=> (smp_q >= $past(smp_q))); // R9
  AST_CLEAR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_RESET) |=> (ref_q == '0 && smp_q == '0)); // R8
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_q) |-> vld_q); // R7
  AST_TIE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && $past(smp_q == ref_q)) |-> !bit_q); // R6

endmodule

// File: rtl/pwm_rot_discrim.sv
module pwm_rot_discrim
  import pwmd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwm_in,
  output logic [NUM_LANES-1:0] bit_out,
  output logic [NUM_LANES-1:0] bit_vld
);

  logic       level;
  logic       rise;
  logic [1:0] phase_eff;

  pwmd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwm_in (pwm_in),
    .level  (level),
    .rise   (rise)
  );

  pwmd_phase_gen u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (rise),
    .phase_eff (phase_eff)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    pwmd_lane #(
      .CNT_W    (CNT_W),
      .LANE_IDX (g)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_eff (phase_eff),
      .rise      (rise),
      .level     (level),
      .bit_o     (bit_out[g]),
      .vld_o     (bit_vld[g])
    );
  end

  AST_ONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bit_vld) <= 1); // R10
  AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (|bit_vld) |-> $past(rise)); // R7

endmodule

// File: tb/pwm_rot_discrim_bench.sv
module pwm_rot_discrim_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0;
  logic [3:0] bit_out;
  logic [3:0] bit_vld;

  always #10 clk = ~clk;

  pwm_rot_discrim u_pwm_rot_discrim (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_in  (pwm_in),
    .bit_out (bit_out),
    .bit_vld (bit_vld)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference model, built from the requirements
  bit m_s1, m_s2, m_prev;
  int m_phase;
  int m_ref[4];
  int m_smp[4];
  bit m_out[4];
  bit m_vld[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_phase = 0;
      for (int l = 0; l < 4; l++) begin
        m_ref[l] = 0; m_smp[l] = 0; m_out[l] = 0; m_vld[l] = 0;
      end
    end else begin
      bit rs;
      int ep;
      rs = m_s2 && !m_prev;                 // R2 period start
      ep = (m_phase + (rs ? 1 : 0)) % 4;    // R3
      for (int l = 0; l < 4; l++) begin
        int st;
        st = (ep - l + 4) % 4;
        m_vld[l] = 0;
        case (st)
          0: if (m_ref[l] < 65535) m_ref[l] = m_ref[l] + 1;                         // R4
          1: if (m_s2) m_smp[l] = (m_smp[l] + 2 > 65535) ? 65535 : m_smp[l] + 2;    // R5 R9
          3: begin
            if (rs) begin m_out[l] = (m_smp[l] > m_ref[l]); m_vld[l] = 1; end      // R6 R7
            m_ref[l] = 0; m_smp[l] = 0;                                             // R8
          end
          default: ;
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pwm_in; m_phase = ep;
    end
  end

  // Expected bit stream for directed checks
  int exp_q[$];
  int vcount = 0;

  function automatic int expect_bit(int prev_p, int h);
    int s, r;
    s = (2 * h > 65535) ? 65535 : 2 * h;
    r = (prev_p > 65535) ? 65535 : prev_p;
    return (s > r) ? 1 : 0;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Per-clock comparison and strobe monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int l = 0; l < 4; l++) begin
        checks++;
        if (bit_out[l] !== m_out[l] || bit_vld[l] !== m_vld[l]) begin
          errors++;
          $display("FAIL R2 R3 R4 R5 R8 lane %0d: bit %0b vld %0b, expected bit %0b vld %0b",
                   l, bit_out[l], bit_vld[l], m_out[l], m_vld[l]);
        end
      end
      checks++;
      if ($countones(bit_vld) > 1) begin
        errors++;
        $display("FAIL R10 valid strobes %b, expected at most one high", bit_vld);
      end
      for (int l = 0; l < 4; l++) begin
        if (bit_vld[l]) begin
          vcount++;
          checks++;
          if (l != (vcount + 1) % 4) begin
            errors++;
            $display("FAIL R7 strobe %0d on lane %0d, expected lane %0d", vcount, l, (vcount + 1) % 4);
          end
          if (vcount > 3) begin
            checks++;
            if (exp_q.size() == 0) begin
              errors++;
              $display("FAIL R7 extra bit on lane %0d: got %0b, expected none", l, bit_out[l]);
            end else begin
              int e;
              e = exp_q.pop_front();
              if (int'(bit_out[l]) != e) begin
                errors++;
                $display("FAIL R6 decoded bit on lane %0d: got %0b, expected %0d", l, bit_out[l], e);
              end
            end
          end
        end
      end
    end
  end

  task automatic send(int p, int h);
    for (int c = 0; c < p; c++) begin
      pwm_in = (c < h);
      @(negedge clk);
    end
  endtask

  int prev_p = 20;

  task automatic send_bit(int p, int h);
    exp_q.push_back(expect_bit(prev_p, h));
    send(p, h);
    prev_p = p;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    pwm_in = 1'b1;
    @(negedge clk);
    checks++;   // R1 reset state, even with the line high
    if (bit_out !== 4'b0 || bit_vld !== 4'b0) begin
      errors++;
      $display("FAIL R1 in reset: bit_out %b bit_vld %b, expected 0000 0000", bit_out, bit_vld);
    end
    pwm_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);

    send(20, 5);          // preamble: the reference it yields comes from idle time
    send_bit(20, 11);     // R6 just above half
    send_bit(20, 10);     // R6 tie resolves to 0
    send_bit(20, 9);
    send_bit(20, 15);
    send_bit(20, 3);
    send_bit(30, 16);     // R4 judged against the previous period's length
    send_bit(30, 15);     // R6 tie
    send_bit(30, 14);
    send_bit(17, 9);
    send_bit(17, 9);
    send_bit(17, 8);
    send_bit(40000, 100);
    send_bit(40000, 35000); // R9 sample count saturates, still greater
    send_bit(20, 15);
    send_bit(20, 12);
    send(20, 5);          // flush: period starts that publish the last two bits
    send(20, 5);
    repeat (10) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 bits never published: %0d, expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule